// File: doc/BRIEF.md
# Phased Reset Sequencer

This block is the state machine that brings a chip out of reset in ordered steps. Reset requests come from eighteen level-sensitive, active-high inputs in two groups. The seven severe-fault inputs restart the whole sequence at phase 0. The eleven lighter-fault inputs restart it at phase 1, so that state guarded by the phase 0 reset, such as debug and flash, is kept. Every request is registered once before it is classified.

The sequencer then steps through phases 0 to 3 and ends in IDLE. Each phase has its own reset output and its own acknowledge slice. A phase ends only when every bit of its slice is high. Its reset is then released and the next phase begins. A hold output keeps the mode manager in its reset mode until IDLE is reached.

Each source also sets a sticky flag, which software clears by writing 1. Power-on acts at once, without the clock. It forces phase 0 and clears every flag except its own.

Top module: `reset_phase_seq`

## Requirements
- R1: Severe-fault bit map: `destrReq[0]` power-on, `[1]` core low-voltage, `[2]` watchdog, `[3]` to `[5]` supply low-voltage detectors, `[6]` comparator error. A request on any of these bits puts the sequencer in phase 0 at the second rising edge after the request is presented, and all four `phaseRst` bits go high.
- R2: Light-fault bit map: `funcReq[0]` external pin, `[1]` JTAG, `[2]` core, `[3]` software, `[4]` checkstop, `[5]` and `[6]` PLL failures, `[7]` oscillator too slow, `[8]` clock monitor out of range, `[9]` high-supply low-voltage, `[10]` flash fatal error. A request on any of these bits while the sequencer is in phase 2, phase 3 or IDLE puts it in phase 1 at the second rising edge. `phaseRst` is then 4'b1110, with bit 0 low.
- R3: A light-fault request that arrives while the sequencer is in phase 0 or phase 1 does not change the phase.
- R4: When severe and light requests are registered in the same cycle, the severe class wins and the sequencer enters phase 0.
- R5: Phase k advances only when all bits of `phaseAck[2k+1:2k]` are high. A partial acknowledge holds the phase.
- R6: `phaseRst[i]` is high while the current phase is i or earlier, and low once phase i has completed. All four bits are low in IDLE.
- R7: `modeHold` is high in every phase and low only in IDLE.
- R8: A registered request sets its flag in `destrFlags` or `funcFlags`, at the same bit position as its request bit. The flag stays set until a cycle in which the matching clear bit is 1.
- R9: If a flag is set and cleared in the same cycle, the set wins.
- R10: While `destrReq[0]` is high, the sequencer is in phase 0 at once, without waiting for a clock edge. `destrFlags` is then 7'b0000001 and `funcFlags` is all zero.
- R11: A severe request that is held high keeps the sequencer in phase 0, even when every acknowledge bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| destrReq | input | 7 | Severe-fault requests, level and active-high; bit 0 is the asynchronous power-on |
| funcReq | input | 11 | Light-fault requests, level and active-high |
| phaseAck | input | 8 | Completion gates, two bits per phase; phase k uses bits 2k+1:2k |
| clrDestr | input | 7 | Write-1-to-clear strobes for the severe-fault flags |
| clrFunc | input | 11 | Write-1-to-clear strobes for the light-fault flags |
| phaseRst | output | 4 | Reset output of each phase, active-high |
| modeHold | output | 1 | Holds the mode manager in its reset mode until IDLE |
| destrFlags | output | 7 | Sticky severe-fault source flags |
| funcFlags | output | 11 | Sticky light-fault source flags |

## Verification
Two kinds of event can fall in the same cycle and are checked for it. The first is a severe request and a light request registered together. The bench drives both on one edge, expects phase 0 and expects both flags to be set. The second is a flag that is set and cleared in the same cycle. The bench presents a light request, then on the next cycle writes 1 to every clear bit. It judges the result by the flag of the registered source surviving while every other flag is cleared.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int PHASES = 4;
  localparam int IDX_W = $clog2(PHASES + 1);

  typedef struct packed {
    logic [PHASES-1:0] phaseOh;
    logic idle;
  } seqStrobe_t;
endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int ACK_W = 2
) (
  input  logic                    clk,
  input  logic                    porIn,
  input  logic                    anyDestr,
  input  logic                    anyFunc,
  input  logic [PHASES*ACK_W-1:0] phaseAck,
  output seqStrobe_t              strobe
);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(PHASES);
  localparam logic [IDX_W-1:0] FIRST_FUNC = IDX_W'(1);

  logic [IDX_W-1:0] phaseIdx, nextIdx;
  logic ackDone;

  always_comb begin
    ackDone = 1'b0;
    for (int k = 0; k < PHASES; k++) begin
      if (phaseIdx == IDX_W'(k)) ackDone = &phaseAck[k*ACK_W +: ACK_W];
    end
  end

  always_comb begin
    nextIdx = phaseIdx;
    if (anyDestr) nextIdx = '0;
    else if (anyFunc && phaseIdx > FIRST_FUNC) nextIdx = FIRST_FUNC;
    else if (phaseIdx != IDLE_IDX && ackDone) nextIdx = phaseIdx + IDX_W'(1);
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) phaseIdx <= '0;
    else phaseIdx <= nextIdx;
  end

  always_comb begin
    for (int k = 0; k < PHASES; k++) strobe.phaseOh[k] = (phaseIdx == IDX_W'(k));
    strobe.idle = (phaseIdx == IDLE_IDX);
  end

  // R1
  destr_restart_chk: assert property (@(posedge clk) disable iff (porIn)
    anyDestr |=> phaseIdx == '0);

  // R2
  func_restart_chk: assert property (@(posedge clk) disable iff (porIn)
    (!anyDestr && anyFunc && phaseIdx > FIRST_FUNC) |=> phaseIdx == FIRST_FUNC);

  // R3
  func_early_chk: assert property (@(posedge clk) disable iff (porIn)
    (!anyDestr && anyFunc && phaseIdx <= FIRST_FUNC && !ackDone) |=> $stable(phaseIdx));

  // R5
  ack_gate_chk: assert property (@(posedge clk) disable iff (porIn)
    (!anyDestr && !anyFunc && phaseIdx != IDLE_IDX && !ackDone) |=> $stable(phaseIdx));
endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int D_SRC   = 7,
  parameter int F_SRC   = 11,
  parameter int POR_BIT = 0
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic [D_SRC-1:0]  destrReq,
  input  logic [F_SRC-1:0]  funcReq,
  input  logic [D_SRC-1:0]  clrDestr,
  input  logic [F_SRC-1:0]  clrFunc,
  input  seqStrobe_t        strobe,
  output logic              anyDestr,
  output logic              anyFunc,
  output logic [PHASES-1:0] phaseRst,
  output logic              modeHold,
  output logic [D_SRC-1:0]  destrFlags,
  output logic [F_SRC-1:0]  funcFlags
);
  localparam logic [D_SRC-1:0] POR_MASK = D_SRC'(1) << POR_BIT;

  logic [D_SRC-1:0] dReg;
  logic [F_SRC-1:0] fReg;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      dReg       <= '0;
      fReg       <= '0;
      destrFlags <= POR_MASK;
      funcFlags  <= '0;
    end else begin
      dReg       <= destrReq;
      fReg       <= funcReq;
      destrFlags <= (destrFlags & ~clrDestr) | dReg;
      funcFlags  <= (funcFlags & ~clrFunc) | fReg;
    end
  end

  assign anyDestr = |dReg;
  assign anyFunc  = |fReg;

  for (genvar i = 0; i < PHASES; i++) begin : g_phaseRst
    assign phaseRst[i] = |strobe.phaseOh[i:0];
  end

  assign modeHold = !strobe.idle;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (porIn)
    1'b1 |=> ((funcFlags & $past(funcFlags & ~clrFunc)) == $past(funcFlags & ~clrFunc)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (porIn)
    1'b1 |=> ((funcFlags & $past(fReg)) == $past(fReg)));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (porIn)
    !modeHold |-> (phaseRst == '0));
endmodule

// File: rtl/reset_phase_seq.sv
module reset_phase_seq
  import rst_seq_pkg::*;
#(
  parameter int D_SRC   = 7,
  parameter int F_SRC   = 11,
  parameter int ACK_W   = 2,
  parameter int POR_BIT = 0
) (
  input  logic                    clk,
  input  logic [D_SRC-1:0]        destrReq,
  input  logic [F_SRC-1:0]        funcReq,
  input  logic [PHASES*ACK_W-1:0] phaseAck,
  input  logic [D_SRC-1:0]        clrDestr,
  input  logic [F_SRC-1:0]        clrFunc,
  output logic [PHASES-1:0]       phaseRst,
  output logic                    modeHold,
  output logic [D_SRC-1:0]        destrFlags,
  output logic [F_SRC-1:0]        funcFlags
);
  logic porIn, anyDestr, anyFunc;
  seqStrobe_t strobe;

  assign porIn = destrReq[POR_BIT];

  rst_seq_ctrl #(.ACK_W(ACK_W)) i_ctrl (
    .clk(clk), .porIn(porIn), .anyDestr(anyDestr), .anyFunc(anyFunc),
    .phaseAck(phaseAck), .strobe(strobe)
  );

  rst_seq_dp #(.D_SRC(D_SRC), .F_SRC(F_SRC), .POR_BIT(POR_BIT)) i_dp (
    .clk(clk), .porIn(porIn), .destrReq(destrReq), .funcReq(funcReq),
    .clrDestr(clrDestr), .clrFunc(clrFunc), .strobe(strobe),
    .anyDestr(anyDestr), .anyFunc(anyFunc), .phaseRst(phaseRst),
    .modeHold(modeHold), .destrFlags(destrFlags), .funcFlags(funcFlags)
  );
endmodule

// File: tb/test_reset_phase_seq.sv
module test_reset_phase_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       req;
    logic [3:0]  rst;
    logic        hold;
    logic [6:0]  df;
    logic [10:0] ff;
  } expItem_t;

  logic        clk = 1'b0;
  logic [6:0]  destrReq = 7'h01;
  logic [10:0] funcReq = '0;
  logic [7:0]  phaseAck = '0;
  logic [6:0]  clrDestr = '0;
  logic [10:0] clrFunc = '0;
  logic [3:0]  phaseRst;
  logic        modeHold;
  logic [6:0]  destrFlags;
  logic [10:0] funcFlags;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  expItem_t scoreQ[$];
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_phase_seq i_reset_phase_seq (
    .clk(clk), .destrReq(destrReq), .funcReq(funcReq), .phaseAck(phaseAck),
    .clrDestr(clrDestr), .clrFunc(clrFunc), .phaseRst(phaseRst),
    .modeHold(modeHold), .destrFlags(destrFlags), .funcFlags(funcFlags)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string req, input logic [3:0] rst, input logic hold,
                           input logic [6:0] df, input logic [10:0] ff);
    expItem_t it;
    it.req = req; it.rst = rst; it.hold = hold; it.df = df; it.ff = ff;
    scoreQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  initial begin
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checks++;
        if (phaseRst !== e.rst || modeHold !== e.hold ||
            destrFlags !== e.df || funcFlags !== e.ff) begin
          fails++;
          $display("FAIL %s: got rst=%b hold=%b df=%h ff=%h, expected rst=%b hold=%b df=%h ff=%h",
                   e.req, phaseRst, modeHold, destrFlags, funcFlags,
                   e.rst, e.hold, e.df, e.ff);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no end of stimulus, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    expectNow("R10 power-on state", 4'b1111, 1'b1, 7'h01, 11'h000);
    destrReq = '0;
    tick(3);
    expectNow("R5 no ack holds phase 0", 4'b1111, 1'b1, 7'h01, 11'h000);
    phaseAck = 8'b0000_0001;
    tick(3);
    expectNow("R5 partial ack holds phase 0", 4'b1111, 1'b1, 7'h01, 11'h000);
    phaseAck = 8'b0000_0111;
    tick(1);
    expectNow("R6 phase 1 releases rst0", 4'b1110, 1'b1, 7'h01, 11'h000);
    phaseAck = 8'b0001_1111;
    tick(2);
    expectNow("R6 phase 2 partial ack", 4'b1100, 1'b1, 7'h01, 11'h000);
    phaseAck = 8'hFF;
    tick(1);
    expectNow("R6 phase 3", 4'b1000, 1'b1, 7'h01, 11'h000);
    tick(1);
    expectNow("R7 idle releases hold", 4'b0000, 1'b0, 7'h01, 11'h000);
    clrDestr = 7'h01;
    tick(1);
    clrDestr = '0;
    tick(1);
    expectNow("R8 write-1 clears flag", 4'b0000, 1'b0, 7'h00, 11'h000);
    phaseAck = '0;
    funcReq = 11'h008;
    tick(1);
    funcReq = '0;
    tick(1);
    expectNow("R2 light fault from idle", 4'b1110, 1'b1, 7'h00, 11'h008);
    funcReq = 11'h008;
    tick(1);
    funcReq = '0;
    tick(2);
    expectNow("R3 light fault in phase 1", 4'b1110, 1'b1, 7'h00, 11'h008);
    phaseAck = 8'b0011_1111;
    tick(3);
    expectNow("R5 phase 3 waits", 4'b1000, 1'b1, 7'h00, 11'h008);
    phaseAck = '0;
    funcReq = 11'h200;
    tick(1);
    funcReq = '0;
    tick(1);
    expectNow("R2 light fault from phase 3", 4'b1110, 1'b1, 7'h00, 11'h208);
    destrReq = 7'h04;
    tick(1);
    destrReq = '0;
    tick(1);
    expectNow("R1 watchdog restarts phase 0", 4'b1111, 1'b1, 7'h04, 11'h208);
    destrReq = 7'h04;
    phaseAck = 8'hFF;
    tick(4);
    expectNow("R11 held severe fault", 4'b1111, 1'b1, 7'h04, 11'h208);
    destrReq = '0;
    tick(6);
    expectNow("R7 idle after release", 4'b0000, 1'b0, 7'h04, 11'h208);
    phaseAck = '0;
    destrReq = 7'h40;
    funcReq = 11'h001;
    tick(1);
    destrReq = '0;
    funcReq = '0;
    tick(1);
    expectNow("R4 severe wins", 4'b1111, 1'b1, 7'h44, 11'h209);
    funcReq = 11'h010;
    tick(1);
    funcReq = '0;
    clrFunc = 11'h7FF;
    tick(1);
    clrFunc = '0;
    expectNow("R9 set beats clear", 4'b1111, 1'b1, 7'h44, 11'h010);
    destrReq = 7'h01;
    #2;
    expectNow("R10 async power-on mid-run", 4'b1111, 1'b1, 7'h01, 11'h000);
    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule